// File: doc/BRIEF.md
# Programmable Interval Timer Channel

The block is one 16-bit down-counting timer channel behind an 8-bit bus. A single select input steers each bus access either to a command port or to a data port. A command byte picks one of three counting behaviours: a periodic rate generator, a one-time terminal-count interrupt level, or a software-armed single strobe. Each of these uses low-then-high byte access with binary counting. A separate command freezes the running count into a holding register so that software can read a consistent value.

After a mode command, software writes the 16-bit start value as two data writes, low byte first. The new value takes effect only when the high byte arrives. The count register decrements once per clock. The single output `tmr_out` is intended to drive an interrupt line. Reads from the data port return the held value if one is frozen, and the live count otherwise. Each read takes two bytes, low byte first.

Top module: `tmr_chan`

## Requirements
- R1: A command byte is acted on only when bits [7:6] are 00. If bits [5:4] are 00, it is a latch command. If bits [5:4] are 11 and bit 0 is 0, bits [3:1] select the mode: 000 is terminal count, 010 is rate generator and 100 is strobe. Any other byte leaves the channel untouched, so 0x34, 0x30 and 0x38 program the three modes and 0x00 latches.
- R2: The start value is taken from two data writes, low byte then high byte. The high-byte write loads the counter. A low-byte write alone does not change counting.
- R3: In rate-generator mode with a start value N of 2 or more, the counter reloads N after reaching 1. The output is high except for one clock in every N, namely the clock in which the count is 1.
- R4: In terminal-count mode the output goes low after the mode command and after each high-byte write. It goes high N clocks after the high-byte write and stays high until the next mode command or count write.
- R5: In strobe mode the output is high except for one low clock, exactly N clocks after the high-byte write. Each later two-byte count write arms one more such pulse.
- R6: A start value of 0 counts as 65536.
- R7: A latch command copies the count present in its cycle into a holding register while counting continues. Further latch commands are ignored while a value is held.
- R8: Data reads return the low byte and then the high byte. The value read is the held count while one is held and the live count otherwise. Reading the high byte releases the hold.
- R9: Every accepted command byte resets both the write byte pointer and the read byte pointer to the low byte.
- R10: After reset the output is high, no count is running and both byte pointers select the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one access per cycle |
| rd_en | input | 1 | Bus read strobe, one access per cycle |
| sel_cmd | input | 1 | 1 selects the command port, 0 the data port |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte from the data port |
| tmr_out | output | 1 | Timer output line |

## Verification
The latch capture and the rate-generator reload can land in the same clock. The held value must then be the pre-reload count, either 1 or the full period, and never a value one step later. The bench provokes this by reprogramming a short period and then issuing the latch command after every possible delay across two full periods. For each delay it predicts the captured value arithmetically from the period and compares the two-byte read against it. A second overlap is a latch command arriving while a value is already held, which must not overwrite the first capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MD_TERM   = 2'd0,
      MD_RATE   = 2'd1,
      MD_STROBE = 2'd2
   } tmr_mode_e;

   typedef struct packed {
      logic      prog;
      logic      latch;
      tmr_mode_e mode;
   } tmr_cmd_s;

   // Command byte: [7:6] channel select, [5:4] access kind, [3:1] mode, [0] BCD
   function automatic tmr_cmd_s decode_cmd(input logic [7:0] b);
      tmr_cmd_s c;
      c.prog  = 1'b0;
      c.latch = 1'b0;
      c.mode  = MD_RATE;
      if (b[7:6] == 2'b00) begin
         if (b[5:4] == 2'b00) begin
            c.latch = 1'b1;
         end else if (b[5:4] == 2'b11 && !b[0]) begin
            case (b[3:1])
               3'b000:  begin c.prog = 1'b1; c.mode = MD_TERM;   end
               3'b010:  begin c.prog = 1'b1; c.mode = MD_RATE;   end
               3'b100:  begin c.prog = 1'b1; c.mode = MD_STROBE; end
               default: ;
            endcase
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
   import tmr_pkg::*;
#(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             sel_cmd,
   input  logic [BUS_W-1:0] wdata,
   output logic             cmd_prog,
   output logic             cmd_latch,
   output tmr_mode_e        cmd_mode,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_word,
   output logic             wr_ptr,
   output logic             rd_ptr,
   output logic             rd_hi_fire
);

   tmr_cmd_s         cmd_c;
   logic             cmd_fire;
   logic             data_wr;
   logic             data_rd;
   logic [BUS_W-1:0] lo_q;

   assign cmd_c     = decode_cmd(wdata);
   assign cmd_fire  = wr_en && sel_cmd;
   assign data_wr   = wr_en && !sel_cmd;
   assign data_rd   = rd_en && !sel_cmd;
   assign cmd_prog  = cmd_fire && cmd_c.prog;
   assign cmd_latch = cmd_fire && cmd_c.latch;
   assign cmd_mode  = cmd_c.mode;

   assign cnt_load   = data_wr && wr_ptr;
   assign cnt_word   = {wdata, lo_q};
   assign rd_hi_fire = data_rd && rd_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= 1'b0;
         rd_ptr <= 1'b0;
         lo_q   <= '0;
      end else if (cmd_prog || cmd_latch) begin
         wr_ptr <= 1'b0;
         rd_ptr <= 1'b0;
      end else begin
         if (data_wr) begin
            if (!wr_ptr) lo_q <= wdata;
            wr_ptr <= !wr_ptr;
         end
         if (data_rd) rd_ptr <= !rd_ptr;
      end
   end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog,
   input  tmr_mode_e        mode_in,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output tmr_mode_e        mode_q,
   output logic             out
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic run_q;
   logic done_q;
   logic arm_q;
   logic fire_q;
   logic at_one;

   assign at_one = run_q && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_RATE;
         cnt    <= '0;
         reload <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         arm_q  <= 1'b0;
         fire_q <= 1'b0;
      end else if (prog) begin
         mode_q <= mode_in;
         run_q  <= 1'b0;
         done_q <= 1'b0;
         arm_q  <= 1'b0;
         fire_q <= 1'b0;
      end else if (load) begin
         cnt    <= load_val;
         reload <= load_val;
         run_q  <= 1'b1;
         done_q <= 1'b0;
         arm_q  <= 1'b1;
         fire_q <= 1'b0;
      end else if (run_q) begin
         if (mode_q == MD_RATE && at_one) cnt <= reload;
         else                             cnt <= cnt - CNT_ONE;
         if (mode_q == MD_TERM && at_one) done_q <= 1'b1;
         fire_q <= (mode_q == MD_STROBE) && arm_q && at_one;
         if (at_one) arm_q <= 1'b0;
      end
   end

   always_comb begin
      case (mode_q)
         MD_TERM:   out = done_q;
         MD_STROBE: out = !fire_q;
         default:   out = !at_one;
      endcase
   end

endmodule

// File: rtl/tmr_latch.sv
module tmr_latch #(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cap,
   input  logic             rel,
   input  logic             rd_ptr,
   input  logic [CNT_W-1:0] cnt,
   output logic             held,
   output logic [CNT_W-1:0] hold,
   output logic [BUS_W-1:0] rdata
);

   logic [CNT_W-1:0] src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         hold <= '0;
      end else if (clr) begin
         held <= 1'b0;
      end else if (cap && !held) begin
         held <= 1'b1;
         hold <= cnt;
      end else if (rel) begin
         held <= 1'b0;
      end
   end

   assign src   = held ? hold : cnt;
   assign rdata = rd_ptr ? src[CNT_W-1:BUS_W] : src[BUS_W-1:0];

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             sel_cmd,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             tmr_out
);

   if (BUS_W != 8) begin : g_bus_bad
      $error("tmr_chan: command decode needs an 8-bit bus");
   end
   if (CNT_W != 2 * BUS_W) begin : g_cnt_bad
      $error("tmr_chan: count must be exactly two bus bytes wide");
   end

   logic             prog_w;
   logic             latch_w;
   tmr_mode_e        cmd_mode_w;
   logic             load_w;
   logic [CNT_W-1:0] word_w;
   logic             wr_ptr_w;
   logic             rd_ptr_w;
   logic             rel_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] reload_w;
   tmr_mode_e        mode_w;
   logic             held_w;
   logic [CNT_W-1:0] hold_w;
   logic             cmd_ok_w;

   assign cmd_ok_w = prog_w || latch_w;

   tmr_bus_if #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .sel_cmd    (sel_cmd),
      .wdata      (wdata),
      .cmd_prog   (prog_w),
      .cmd_latch  (latch_w),
      .cmd_mode   (cmd_mode_w),
      .cnt_load   (load_w),
      .cnt_word   (word_w),
      .wr_ptr     (wr_ptr_w),
      .rd_ptr     (rd_ptr_w),
      .rd_hi_fire (rel_w)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog     (prog_w),
      .mode_in  (cmd_mode_w),
      .load     (load_w),
      .load_val (word_w),
      .cnt      (cnt_w),
      .reload   (reload_w),
      .mode_q   (mode_w),
      .out      (tmr_out)
   );

   tmr_latch #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (prog_w),
      .cap    (latch_w),
      .rel    (rel_w),
      .rd_ptr (rd_ptr_w),
      .cnt    (cnt_w),
      .held   (held_w),
      .hold   (hold_w),
      .rdata  (rdata)
   );

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic             tmr_out,
   input tmr_mode_e        mode,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic             held,
   input logic [CNT_W-1:0] hold,
   input logic             wr_ptr,
   input logic             rd_ptr,
   input logic             cmd_ok
);

   // R3
   rate_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_RATE && !tmr_out && !wr_en) |=> (cnt == reload));

   // R4
   term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_TERM && tmr_out && !wr_en) |=> tmr_out);

   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_STROBE && !tmr_out) |=> tmr_out);

   // R7
   latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !wr_en && !rd_en) |=> (held && $stable(hold)));

   // R9
   ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ok |=> (!wr_ptr && !rd_ptr));

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .tmr_out (tmr_out),
   .mode    (mode_w),
   .cnt     (cnt_w),
   .reload  (reload_w),
   .held    (held_w),
   .hold    (hold_w),
   .wr_ptr  (wr_ptr_w),
   .rd_ptr  (rd_ptr_w),
   .cmd_ok  (cmd_ok_w)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       sel_cmd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       tmr_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = !clk;

   tmr_chan u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .sel_cmd (sel_cmd),
      .wdata   (wdata),
      .rdata   (rdata),
      .tmr_out (tmr_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] v);
      wr_en = 1'b1; sel_cmd = a; wdata = v;
      @(negedge clk);
      wr_en = 1'b0; sel_cmd = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      rd_en = 1'b1; sel_cmd = 1'b0;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic prog(input logic [7:0] cmd, input logic [15:0] n);
      wr(1'b1, cmd);
      wr(1'b0, n[7:0]);
      wr(1'b0, n[15:8]);
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic rd_word(output logic [15:0] v);
      logic [7:0] lo;
      logic [7:0] hi;
      rd(lo);
      rd(hi);
      v = {hi, lo};
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      logic [15:0] w;
      logic [7:0]  b;
      bit          bad;
      int          per [5] = '{2, 3, 5, 8, 13};
      int          tn  [3] = '{1, 4, 9};
      int          sn  [3] = '{1, 3, 6};

      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 out after reset", int'(tmr_out), 1);
      rd(b);
      chk("R10 low byte first after reset", int'(b), 0);

      // R3 / R1: rate generator sweep over several periods, command 0x34
      foreach (per[k]) begin
         prog(8'h34, 16'(per[k]));
         for (int i = 0; i < 3 * per[k]; i++) begin
            chk("R3 rate output", int'(tmr_out), ((i + 1) % per[k] != 0) ? 1 : 0);
            @(negedge clk);
         end
      end

      // R4 / R1: terminal count, command 0x30
      foreach (tn[k]) begin
         wr(1'b1, 8'h30);
         chk("R4 low after command", int'(tmr_out), 0);
         wr(1'b0, 8'(tn[k]));
         wr(1'b0, 8'h00);
         for (int i = 0; i < tn[k] + 4; i++) begin
            chk("R4 terminal output", int'(tmr_out), (i >= tn[k]) ? 1 : 0);
            @(negedge clk);
         end
      end

      // R5 / R1: strobe, command 0x38, and rearm with a second count write
      foreach (sn[k]) begin
         prog(8'h38, 16'(sn[k]));
         for (int i = 0; i < sn[k] + 4; i++) begin
            chk("R5 strobe output", int'(tmr_out), (i == sn[k]) ? 0 : 1);
            @(negedge clk);
         end
         wr(1'b0, 8'(sn[k]));
         wr(1'b0, 8'h00);
         for (int i = 0; i < sn[k] + 4; i++) begin
            chk("R5 strobe rearm", int'(tmr_out), (i == sn[k]) ? 0 : 1);
            @(negedge clk);
         end
      end

      // R2: low byte alone does not start counting
      wr(1'b1, 8'h30);
      wr(1'b0, 8'h05);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (tmr_out) bad = 1;
         @(negedge clk);
      end
      chk("R2 no count before high byte", int'(bad), 0);
      wr(1'b0, 8'h00);
      idle(4);
      chk("R2 count 5 not yet expired", int'(tmr_out), 0);
      @(negedge clk);
      chk("R2 count 5 expired", int'(tmr_out), 1);

      // R9: command between low and high byte resets write pointer
      wr(1'b1, 8'h34);
      wr(1'b0, 8'h07);
      prog(8'h34, 16'd4);
      for (int i = 0; i < 12; i++) begin
         chk("R9 period after pointer reset", int'(tmr_out), ((i + 1) % 4 != 0) ? 1 : 0);
         @(negedge clk);
      end

      // R1: ignored command bytes leave counting alone
      prog(8'h34, 16'd5);
      wr(1'b1, 8'h74);
      wr(1'b1, 8'h35);
      wr(1'b1, 8'h3C);
      for (int i = 3; i < 15; i++) begin
         chk("R1 ignored commands", int'(tmr_out), ((i + 1) % 5 != 0) ? 1 : 0);
         @(negedge clk);
      end

      // R7 / R8: latch, second latch ignored, then live reads
      prog(8'h34, 16'd1000);
      idle(10);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h00);
      idle(5);
      rd_word(w);
      chk("R7 held value", int'(w), 990);
      rd(b);
      chk("R8 live low byte", int'(b), 981 & 8'hFF);
      rd(b);
      chk("R8 live high byte", int'(b), 980 >> 8);

      // R7 / R3: latch swept across the reload point
      for (int i = 0; i < 14; i++) begin
         prog(8'h34, 16'd6);
         idle(i);
         wr(1'b1, 8'h00);
         idle(3);
         rd_word(w);
         chk("R7 latch vs reload", int'(w), 6 - (i % 6));
      end

      // R6: zero means 65536
      prog(8'h34, 16'd0);
      idle(1);
      wr(1'b1, 8'h00);
      rd_word(w);
      chk("R6 zero wraps", int'(w), 16'hFFFF);
      prog(8'h38, 16'd0);
      idle(65535);
      chk("R6 strobe before 65536", int'(tmr_out), 1);
      @(negedge clk);
      chk("R6 strobe at 65536", int'(tmr_out), 0);
      @(negedge clk);
      chk("R6 strobe after 65536", int'(tmr_out), 1);

      // R4 / R6: zero count in terminal mode stops periodic output
      prog(8'h30, 16'd0);
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         if (tmr_out) bad = 1;
         @(negedge clk);
      end
      chk("R4 stopped by zero count", int'(bad), 0);

      summary();
   end

endmodule